// File: doc/BRIEF.md
# Zero-turnaround flow-through SRAM core

This block is a synchronous single-port memory. Every operation takes two cycles. In the first cycle, called the address cycle, the address, the direction and the byte mask are captured on a rising clock edge. The second cycle, called the data cycle, carries the data for that operation. A read's data leaves the array combinationally during its data cycle and passes through no output register. A write's data is taken from the data-in bus during its data cycle. It is committed to the array on the edge that closes that cycle. Because reads and writes both place their data one cycle after their address, any mix of the two runs at full rate with no idle cycle on the data bus.

Three chip selects gate the start of new operations. Two of them are active-low and one is active-high. A load/advance input picks between two actions: loading a fresh address, or stepping a four-beat burst from the previous address in the same direction. An active-low clock enable freezes the whole block. An asynchronous output enable and a sleep input can turn off the output drive at any time. Sleep also blocks new operations and keeps the memory contents intact. The tri-state data bus is split into three separate signals: data-in, data-out and an output-drive flag.

Top module: `ztsram_core`

## Requirements
- R1: Data driven on `din` during the data cycle of a write (the cycle after its address edge) is stored at the write's address. A later read of that address returns it.
- R2: After a read's address edge, the data cycle shows the stored word on `dout` with `dout_en` high. This happens combinationally, with no further clock edge.
- R3: Reads and writes in any order may be issued on consecutive edges with no idle cycle. A read issued on the edge right after a write to the same address returns the newly written word.
- R4: While `cen_n` is high, every synchronous input is ignored and all internal state holds. A pending write commits at the first enabled edge, using the `din` present at that edge.
- R5: A new operation starts at an edge only when all of these hold: `adv_ld` is 0, `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0. If any select is inactive on a load, the block is deselected, and `dout_en` is low in the following cycle.
- R6: A deselect does not cancel the data cycle of an operation already issued. A write issued just before a deselect still stores the `din` of its data cycle.
- R7: `dout_en` is low during the data cycle of a write and during the cycle that follows a deselect.
- R8: `oe_n` high forces `dout_en` low at once, at any time. Lowering `oe_n` again during a read data cycle restores the drive without a clock edge.
- R9: `bw_n[i]`, sampled at the write's address edge, enables lane i, which is `din[9i+8:9i]`. A 0 writes the lane and a 1 leaves the stored lane unchanged.
- R10: With `adv_ld` = 1 after an active operation, a new beat starts in the same direction. Its address has the low two bits incremented modulo 4 and the upper bits unchanged. With `adv_ld` = 1 while deselected, the block stays deselected.
- R11: While `sleep` is 1, no new operation starts, `dout_en` is held low and the memory contents are preserved.
- R12: After reset, no operation is pending and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Clock enable, active low; high freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| rd_wr_n | input | 1 | 1 read, 0 write (sampled on load) |
| bw_n | input | 4 | Per-lane write enables, active low |
| addr | input | AW | Word address |
| din | input | 36 | Write data, taken during the data cycle |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request |
| dout | output | 36 | Read data (zero when not driven) |
| dout_en | output | 1 | Output drive active |

## Verification
Read data and `dout_en` are due in the cycle after the address edge. `oe_n` and `sleep` act on `dout_en` within the same cycle, with no edge. A write becomes visible to a read issued on the very next edge. Each scenario drives its inputs just after a rising edge, then samples 2 ns after the following rising edge, when the data cycle of the operation just issued is under way. The `din` given with a step belongs to the operation issued in the previous step. Freeze tests and output-enable tests sample again inside the same held cycle, without waiting for another edge.

// File: rtl/ztsram_pkg.sv
package ztsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int BEAT_W = 2;

  typedef enum logic {
    XFER_WR = 1'b0,
    XFER_RD = 1'b1
  } xfer_e;
endpackage

// File: rtl/ztsram_beat.sv
// Next-beat address: low BEAT_W bits wrap, upper bits stay.
module ztsram_beat
  import ztsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  logic [BEAT_W-1:0] beat_nxt;

  always_comb begin
    beat_nxt = cur_addr[BEAT_W-1:0] + BEAT_W'(1);
    nxt_addr = {cur_addr[AW-1:BEAT_W], beat_nxt};
  end
endmodule

// File: rtl/ztsram_ctrl.sv
// Address/control stage: holds the operation whose data cycle is current.
module ztsram_ctrl
  import ztsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              adv_ld,
  input  logic              rd_wr_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [AW-1:0]     addr,
  input  logic              sleep,
  output logic              stg_vld,
  output xfer_e             stg_dir,
  output logic [AW-1:0]     stg_addr,
  output logic [LANES-1:0]  stg_mask,
  output logic              commit
);
  logic             sel_ok;
  logic             start_op;
  logic             cont_op;
  logic             vld_d;
  xfer_e            dir_d;
  logic [AW-1:0]    addr_d;
  logic [LANES-1:0] mask_d;
  logic [AW-1:0]    beat_addr;

  ztsram_beat #(.AW(AW)) u_beat (
    .cur_addr (stg_addr),
    .nxt_addr (beat_addr)
  );

  always_comb begin
    sel_ok   = !sel_a_n && sel_b && !sel_c_n;
    start_op = !adv_ld && sel_ok && !sleep;
    cont_op  = adv_ld && stg_vld && !sleep;
    vld_d    = start_op || cont_op;
    dir_d    = stg_dir;
    addr_d   = stg_addr;
    mask_d   = stg_mask;
    if (start_op) begin
      dir_d  = rd_wr_n ? XFER_RD : XFER_WR;
      addr_d = addr;
      mask_d = ~bw_n;
    end else if (cont_op) begin
      addr_d = beat_addr;
      mask_d = ~bw_n;
    end
  end

  // Write commits on the edge closing its data cycle.
  assign commit = !cen_n && stg_vld && (stg_dir == XFER_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld  <= 1'b0;
      stg_dir  <= XFER_RD;
      stg_addr <= '0;
      stg_mask <= '0;
    end else if (!cen_n) begin
      stg_vld  <= vld_d;
      stg_dir  <= dir_d;
      stg_addr <= addr_d;
      stg_mask <= mask_d;
    end
  end
endmodule

// File: rtl/ztsram_array.sv
// Storage split into byte lanes; combinational read, lane-masked write.
module ztsram_array
  import ztsram_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  lane_en,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we && lane_en[g]) begin
        cells[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
  end
endmodule

// File: rtl/ztsram_core.sv
module ztsram_core
  import ztsram_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              adv_ld,
  input  logic              rd_wr_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] din,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);
  logic              stg_vld;
  xfer_e             stg_dir;
  logic [AW-1:0]     stg_addr;
  logic [LANES-1:0]  stg_mask;
  logic              commit;
  logic [WORD_W-1:0] rdata;
  logic              stg_rd;

  ztsram_ctrl #(.AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cen_n    (cen_n),
    .sel_a_n  (sel_a_n),
    .sel_b    (sel_b),
    .sel_c_n  (sel_c_n),
    .adv_ld   (adv_ld),
    .rd_wr_n  (rd_wr_n),
    .bw_n     (bw_n),
    .addr     (addr),
    .sleep    (sleep),
    .stg_vld  (stg_vld),
    .stg_dir  (stg_dir),
    .stg_addr (stg_addr),
    .stg_mask (stg_mask),
    .commit   (commit)
  );

  ztsram_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk     (clk),
    .we      (commit),
    .lane_en (stg_mask),
    .waddr   (stg_addr),
    .wdata   (din),
    .raddr   (stg_addr),
    .rdata   (rdata)
  );

  // Flow-through: drive depends on stage state and two async gates.
  assign stg_rd  = (stg_dir == XFER_RD);
  assign dout_en = stg_vld && stg_rd && !oe_n && !sleep;
  assign dout    = dout_en ? rdata : '0;
endmodule

// File: rtl/ztsram_chk.sv
module ztsram_chk (
  input logic clk,
  input logic rst_n,
  input logic cen_n,
  input logic sel_a_n,
  input logic sel_b,
  input logic sel_c_n,
  input logic adv_ld,
  input logic rd_wr_n,
  input logic oe_n,
  input logic sleep,
  input logic dout_en,
  input logic stg_vld,
  input logic stg_rd
);
  logic sel_ok;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_quiet_r12: assert (!dout_en && !stg_vld);
    end
  end

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  p_sleep_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(stg_vld) && $stable(stg_rd)));

  p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && !sel_ok) |=> !dout_en);

  p_write_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && sel_ok && !sleep && !rd_wr_n) |=> !dout_en);

  p_read_flow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && sel_ok && !sleep && rd_wr_n) |=> (dout_en == (!oe_n && !sleep)));

  p_beat_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && stg_vld && !sleep) |=> (stg_vld && (stg_rd == $past(stg_rd))));
endmodule

bind ztsram_core ztsram_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cen_n   (cen_n),
  .sel_a_n (sel_a_n),
  .sel_b   (sel_b),
  .sel_c_n (sel_c_n),
  .adv_ld  (adv_ld),
  .rd_wr_n (rd_wr_n),
  .oe_n    (oe_n),
  .sleep   (sleep),
  .dout_en (dout_en),
  .stg_vld (stg_vld),
  .stg_rd  (stg_rd)
);

// File: tb/sim_ztsram_core.sv
`timescale 1ns/1ps
module sim_ztsram_core;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [35:0] D1 = 36'hA5A5A5A5A;
  localparam logic [35:0] D2 = 36'h123456789;
  localparam logic [35:0] JUNK = 36'hDEADBEEF0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cen_n, sel_a_n, sel_b, sel_c_n, adv_ld, rd_wr_n, oe_n, sleep;
  logic [3:0]  bw_n;
  logic [AW-1:0] addr;
  logic [35:0] din;
  logic [35:0] dout;
  logic        dout_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ztsram_core #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .adv_ld(adv_ld), .rd_wr_n(rd_wr_n), .bw_n(bw_n),
    .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep), .dout(dout),
    .dout_en(dout_en)
  );

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: sets control for a new op plus din for the op issued last step.
  task automatic step(input logic adv, input logic en, input logic rd,
                      input logic [AW-1:0] a, input logic [3:0] bw, input logic [35:0] d);
    adv_ld = adv; sel_a_n = 1'b0; sel_b = en; sel_c_n = 1'b0;
    rd_wr_n = rd; addr = a; bw_n = bw; din = d;
    @(posedge clk); #2;
  endtask

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                        input logic [3:0] bw);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (!bw[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic t_reset();
    chk("R12 dout_en after reset", {35'd0, dout_en}, 36'd0);
    chk("R12 dout after reset", dout, 36'd0);
  endtask

  task automatic t_write_read();
    step(0, 1, 0, 6'd5, 4'h0, JUNK);
    chk("R7 no drive in write data cycle", {35'd0, dout_en}, 36'd0);
    step(0, 0, 1, 6'd0, 4'hF, D2);
    chk("R7 no drive after deselect", {35'd0, dout_en}, 36'd0);
    step(0, 1, 1, 6'd5, 4'hF, JUNK);
    chk("R2 read drive", {35'd0, dout_en}, 36'd1);
    chk("R1 read back written word", dout, D2);
  endtask

  task automatic t_b2b();
    step(0, 1, 0, 6'd10, 4'h0, JUNK);
    step(0, 1, 1, 6'd10, 4'hF, D1);
    chk("R3 read right after write", dout, D1);
    step(0, 1, 0, 6'd11, 4'h0, JUNK);
    chk("R3 write after read no drive", {35'd0, dout_en}, 36'd0);
    step(0, 1, 1, 6'd11, 4'hF, D2);
    chk("R3 read 11 after write", dout, D2);
    step(0, 1, 1, 6'd10, 4'hF, JUNK);
    chk("R3 read 10 back to back", dout, D1);
    step(0, 0, 1, 6'd0, 4'hF, JUNK);
  endtask

  task automatic t_bytes();
    logic [35:0] nw;
    nw = 36'h0F0F0F0F0;
    step(0, 1, 0, 6'd20, 4'h0, JUNK);
    step(0, 1, 0, 6'd20, 4'b1010, 36'hFFFFFFFFF);
    step(0, 1, 1, 6'd20, 4'hF, nw);
    chk("R9 lane mask merge", dout, merge(36'hFFFFFFFFF, nw, 4'b1010));
    step(0, 0, 1, 6'd0, 4'hF, JUNK);
  endtask

  task automatic t_cen();
    step(0, 1, 1, 6'd10, 4'hF, JUNK);
    cen_n = 1'b1; adv_ld = 0; rd_wr_n = 0; addr = 6'd11; bw_n = 4'h0; din = JUNK;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #2;
      chk("R4 held read data", dout, D1);
      chk("R4 held read drive", {35'd0, dout_en}, 36'd1);
    end
    cen_n = 1'b0;
    step(0, 0, 1, 6'd0, 4'hF, JUNK);
    chk("R4 ignored load started nothing", {35'd0, dout_en}, 36'd0);
    step(0, 1, 0, 6'd30, 4'h0, JUNK);
    cen_n = 1'b1; din = JUNK;
    repeat (2) @(posedge clk);
    #2; cen_n = 1'b0;
    step(0, 0, 1, 6'd0, 4'hF, D2);
    step(0, 1, 1, 6'd30, 4'hF, JUNK);
    chk("R4 write commits on enabled edge", dout, D2);
    step(0, 0, 1, 6'd0, 4'hF, JUNK);
  endtask

  task automatic t_desel();
    for (int k = 0; k < 3; k++) begin
      adv_ld = 0; rd_wr_n = 1; addr = 6'd10; bw_n = 4'hF;
      sel_a_n = (k == 0); sel_b = (k != 1); sel_c_n = (k == 2);
      @(posedge clk); #2;
      chk("R5 inactive select blocks read", {35'd0, dout_en}, 36'd0);
    end
    step(0, 1, 0, 6'd40, 4'h0, JUNK);
    step(0, 0, 1, 6'd0, 4'hF, D1);
    step(0, 1, 1, 6'd40, 4'hF, JUNK);
    chk("R6 write before deselect completes", dout, D1);
    step(0, 0, 1, 6'd0, 4'hF, JUNK);
  endtask

  task automatic t_oe();
    step(0, 1, 1, 6'd11, 4'hF, JUNK);
    oe_n = 1'b1; #1;
    chk("R8 oe off forces no drive", {35'd0, dout_en}, 36'd0);
    oe_n = 1'b0; #1;
    chk("R8 oe back on restores drive", {35'd0, dout_en}, 36'd1);
    chk("R8 data after oe restore", dout, D2);
    step(0, 0, 1, 6'd0, 4'hF, JUNK);
  endtask

  task automatic t_burst();
    logic [35:0] w [4];
    for (int i = 0; i < 4; i++) w[i] = 36'h111111111 * (i + 3);
    step(0, 1, 0, 6'h21, 4'h0, JUNK);
    step(1, 1, 0, 6'h00, 4'h0, w[0]);
    step(1, 1, 0, 6'h00, 4'h0, w[1]);
    step(1, 1, 0, 6'h00, 4'h0, w[2]);
    step(0, 0, 1, 6'h00, 4'hF, w[3]);
    step(1, 1, 1, 6'h00, 4'hF, JUNK);
    chk("R10 advance while deselected stays idle", {35'd0, dout_en}, 36'd0);
    step(0, 1, 1, 6'h21, 4'hF, JUNK);
    chk("R10 beat 0 at 21", dout, w[0]);
    step(1, 1, 0, 6'h00, 4'hF, JUNK);
    chk("R10 beat 1 at 22 keeps read", dout, w[1]);
    step(1, 1, 0, 6'h00, 4'hF, JUNK);
    chk("R10 beat 2 at 23", dout, w[2]);
    step(1, 1, 0, 6'h00, 4'hF, JUNK);
    chk("R10 beat 3 wraps to 20", dout, w[3]);
    step(0, 0, 1, 6'd0, 4'hF, JUNK);
  endtask

  task automatic t_sleep();
    step(0, 1, 1, 6'd10, 4'hF, JUNK);
    sleep = 1'b1; #1;
    chk("R11 sleep drops drive", {35'd0, dout_en}, 36'd0);
    step(0, 1, 1, 6'd10, 4'hF, JUNK);
    chk("R11 read blocked in sleep", {35'd0, dout_en}, 36'd0);
    step(0, 1, 0, 6'd10, 4'h0, JUNK);
    step(0, 0, 1, 6'd0, 4'hF, 36'd0);
    sleep = 1'b0;
    step(0, 1, 1, 6'd10, 4'hF, JUNK);
    chk("R11 contents kept through sleep", dout, D1);
    step(0, 0, 1, 6'd0, 4'hF, JUNK);
  endtask

  initial begin
    rst_n = 1'b0; cen_n = 1'b0; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
    adv_ld = 1'b0; rd_wr_n = 1'b1; bw_n = 4'hF; addr = '0; din = '0;
    oe_n = 1'b0; sleep = 1'b0;
    repeat (3) @(posedge clk);
    #2; t_reset();
    rst_n = 1'b1;
    @(posedge clk); #2;
    t_write_read();
    t_b2b();
    t_bytes();
    t_cen();
    t_desel();
    t_oe();
    t_burst();
    t_sleep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule